// File: doc/BRIEF.md
# Supply Monitor Interrupt Controller

This block sits between a digital low-voltage comparator output and the processor's interrupt and reset logic. The comparator level arrives asynchronously; the block brings it into the clock domain, remembers every change of that level in a sticky flag, and turns the flag into an interrupt request when software has allowed it. Software clears the flag through an acknowledge bit that only takes effect when written with 1 and always reads back as 0.

The block can also ask the system for a reset while the comparator reports low voltage. A reset request always takes precedence: while reset generation is enabled, no interrupt is raised. The block keeps running in wait mode. In stop mode it only keeps running when its stop-enable bit is set; otherwise it neither records changes nor raises requests.

Everything software sees lives in one byte-wide control register with a single write strobe and a read port that shows the register contents at all times.

Top module: `supmon_irq_ctrl`

## Requirements
- R1: The comparator input passes through two synchronizer flops; a level applied before clock edge k appears in register bit 5 (live level, 1 = low voltage) after edge k+1.
- R2: While the block is active, the flag in bit 1 is set one edge after bit 5 changes value, for a rise as well as a fall.
- R3: The flag cannot be written directly; it is cleared only by a write with bit 2 (acknowledge) at 1, and a write with bit 2 at 0 leaves it unchanged.
- R4: Bit 2 and bits 7:6 always read 0; bit 0 (interrupt enable), bit 3 (reset enable) and bit 4 (stop enable) read back the last value written.
- R5: `irq_o` is high in the cycle after one in which bit 0 and bit 1 are both 1, bit 3 is 0 and the block is active, and low otherwise.
- R6: While bit 3 is 1, `irq_o` stays low, whatever the flag and bit 0 hold.
- R7: `rst_req_o` is a single-cycle pulse, one edge after the condition "bit 3 = 1, bit 5 = 1, block active" becomes true; it pulses again only after that condition has dropped and returned.
- R8: `pwr_mode` = 2'b01 (wait) behaves exactly like 2'b00 (run): the flag, `irq_o` and `rst_req_o` follow the same rules.
- R9: With `pwr_mode` = 2'b10 (stop) and bit 4 = 0 the block is inactive: level changes do not set the flag and both request outputs stay low; with bit 4 = 1 it behaves as in run mode. Code 2'b11 is treated as run.
- R10: When a flag-setting change and an acknowledge write fall in the same cycle, the flag is set afterwards.
- R11: A synchronous reset clears bits 0, 1, 3, 4 and 5 and drives both request outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data for the control register |
| rd_data | output | 8 | Current control register contents |
| comp_in | input | 1 | Asynchronous comparator output, 1 = low voltage |
| pwr_mode | input | 2 | 00 run, 01 wait, 10 stop, 11 run |
| irq_o | output | 1 | Interrupt request, registered |
| rst_req_o | output | 1 | Reset request pulse, registered |

## Verification
The flag can be set by a level change and cleared by an acknowledge write in the same cycle. The bench provokes this by toggling the comparator and then writing the acknowledge bit after a sweep of delays, so that one of the writes lands on the exact cycle the synchronized level changes. The behavioural model applies set-over-clear and judges the read data and interrupt output on every cycle of the sweep.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_IE  = 0;
  localparam int BIT_FLG = 1;
  localparam int BIT_ACK = 2;
  localparam int BIT_RE  = 3;
  localparam int BIT_SE  = 4;
  localparam int BIT_LVL = 5;

  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_WAIT = 2'b01,
    PM_STOP = 2'b10,
    PM_RSV  = 2'b11
  } pwr_mode_e;

  typedef struct packed {
    logic stop_en;
    logic rst_en;
    logic irq_en;
  } ctrl_t;
endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic toggle
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain[TOP];
  end

  assign level  = chain[TOP];
  assign toggle = chain[TOP] ^ prev_q;
endmodule

// File: rtl/supmon_ctrl_regs.sv
module supmon_ctrl_regs
  import supmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             toggle,
  input  logic             active,
  output ctrl_t            ctrl,
  output logic             flag
);
  logic ack_hit;
  assign ack_hit = wr_en & wr_data[BIT_ACK];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_en) begin
      ctrl.irq_en  <= wr_data[BIT_IE];
      ctrl.rst_en  <= wr_data[BIT_RE];
      ctrl.stop_en <= wr_data[BIT_SE];
    end
  end

  // set dominates clear when both land in one cycle
  always_ff @(posedge clk) begin
    if (rst)                   flag <= 1'b0;
    else if (toggle && active) flag <= 1'b1;
    else if (ack_hit)          flag <= 1'b0;
  end
endmodule

// File: rtl/supmon_req_gen.sv
module supmon_req_gen (
  input  logic clk,
  input  logic rst,
  input  logic irq_en,
  input  logic rst_en,
  input  logic flag,
  input  logic level,
  input  logic active,
  output logic irq_o,
  output logic rst_req_o
);
  logic rst_cond;
  logic rst_cond_q;

  assign rst_cond = rst_en & level & active;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o      <= 1'b0;
      rst_req_o  <= 1'b0;
      rst_cond_q <= 1'b0;
    end else begin
      irq_o      <= irq_en & flag & ~rst_en & active;
      rst_req_o  <= rst_cond & ~rst_cond_q;
      rst_cond_q <= rst_cond;
    end
  end
endmodule

// File: rtl/supmon_irq_ctrl.sv
module supmon_irq_ctrl
  import supmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             comp_in,
  input  logic [1:0]       pwr_mode,
  output logic             irq_o,
  output logic             rst_req_o
);
  logic  level;
  logic  toggle;
  logic  flag;
  logic  active;
  ctrl_t ctrl;

  supmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din    (comp_in),
    .level  (level),
    .toggle (toggle)
  );

  assign active = (pwr_mode != PM_STOP) | ctrl.stop_en;

  supmon_ctrl_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .toggle  (toggle),
    .active  (active),
    .ctrl    (ctrl),
    .flag    (flag)
  );

  supmon_req_gen u_req (
    .clk       (clk),
    .rst       (rst),
    .irq_en    (ctrl.irq_en),
    .rst_en    (ctrl.rst_en),
    .flag      (flag),
    .level     (level),
    .active    (active),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  always_comb begin
    rd_data          = '0;
    rd_data[BIT_IE]  = ctrl.irq_en;
    rd_data[BIT_FLG] = flag;
    rd_data[BIT_RE]  = ctrl.rst_en;
    rd_data[BIT_SE]  = ctrl.stop_en;
    rd_data[BIT_LVL] = level;
  end
endmodule

// File: rtl/supmon_irq_chk.sv
module supmon_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [1:0] pwr_mode,
  input logic       irq_o,
  input logic       rst_req_o
);
  logic act;
  assign act = (pwr_mode != 2'b10) | rd_data[4];

  assert_ack_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_data[2] == 1'b0) && (rd_data[7:6] == 2'b00));

  assert_flag_on_change_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_data[5] != $past(rd_data[5])) && act |=> rd_data[1]);

  assert_flag_holds_R3: assert property (@(posedge clk) disable iff (rst)
    rd_data[1] && !(wr_en && wr_data[2]) |=> rd_data[1]);

  assert_no_irq_with_reset_R6: assert property (@(posedge clk) disable iff (rst)
    rd_data[3] |=> !irq_o);

  assert_reset_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);

  assert_stop_silent_R9: assert property (@(posedge clk) disable iff (rst)
    !act |=> !irq_o && !rst_req_o);

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (rd_data == 8'h00) && !irq_o && !rst_req_o);
endmodule

bind supmon_irq_ctrl supmon_irq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .pwr_mode  (pwr_mode),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o)
);

// File: tb/tb_supmon_irq_ctrl.sv
module tb_supmon_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       comp_in = 1'b0;
  logic [1:0] pwr_mode = 2'b00;
  logic       irq_o;
  logic       rst_req_o;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string phase = "R11";

  always #2 clk = ~clk;

  supmon_irq_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .comp_in(comp_in), .pwr_mode(pwr_mode), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  // behavioural reference: history of sampled comparator values, newest first
  bit hist[$];
  bit m_ie, m_re, m_se, m_flag, m_irq, m_rreq, m_cond_seen;

  initial begin
    hist = '{1'b0, 1'b0, 1'b0};
    {m_ie, m_re, m_se, m_flag, m_irq, m_rreq, m_cond_seen} = '0;
  end

  always @(posedge clk) begin
    bit lvl, prv, act, chg, cond;
    if (rst) begin
      hist = '{1'b0, 1'b0, 1'b0};
      {m_ie, m_re, m_se, m_flag, m_irq, m_rreq, m_cond_seen} = '0;
    end else begin
      lvl  = hist[1];
      prv  = hist[2];
      chg  = (lvl != prv);
      act  = !(pwr_mode == 2'b10) || m_se;
      cond = m_re && lvl && act;
      m_irq  = m_ie && m_flag && !m_re && act;
      m_rreq = cond && !m_cond_seen;
      m_cond_seen = cond;
      if (chg && act)           m_flag = 1'b1;
      else if (wr_en && wr_data[2]) m_flag = 1'b0;
      if (wr_en) begin
        m_ie = wr_data[0];
        m_re = wr_data[3];
        m_se = wr_data[4];
      end
      hist.push_front(comp_in);
      void'(hist.pop_back());
    end
  end

  task automatic compare();
    logic [7:0] exp_rd;
    exp_rd = {2'b00, hist[1], m_se, m_re, 1'b0, m_flag, m_ie};
    vectors++;
    if (rd_data !== exp_rd) begin
      miscompares++;
      $display("FAIL %s rd_data actual %h expected %h", phase, rd_data, exp_rd);
    end
    if (irq_o !== m_irq) begin
      miscompares++;
      $display("FAIL %s irq_o actual %b expected %b", phase, irq_o, m_irq);
    end
    if (rst_req_o !== m_rreq) begin
      miscompares++;
      $display("FAIL %s rst_req_o actual %b expected %b", phase, rst_req_o, m_rreq);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
      wr_en = 1'b0;
    end
  endtask

  task automatic wr(logic [7:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    tick(1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R11: reset state, comparator held high during reset
    comp_in = 1'b1;
    tick(3);
    rst = 1'b0;
    comp_in = 1'b0;
    tick(3);

    // R4: unused and acknowledge bits read zero, enables read back
    phase = "R4";
    wr(8'hFF);
    tick(2);
    wr(8'h00);
    tick(2);

    // R1 / R5: rising level sets flag and raises interrupt
    phase = "R1";
    wr(8'h01);
    comp_in = 1'b1;
    tick(2);
    phase = "R5";
    tick(4);

    // R3: write without acknowledge keeps flag, then acknowledge clears
    phase = "R3";
    wr(8'h01);
    tick(2);
    wr(8'h05);
    tick(3);

    // R2: falling level sets the flag again
    phase = "R2";
    comp_in = 1'b0;
    tick(5);
    wr(8'h05);
    tick(2);

    // R6 / R7: reset enabled beats interrupt; pulse per condition rise
    phase = "R6";
    wr(8'h09);
    comp_in = 1'b1;
    tick(6);
    phase = "R7";
    comp_in = 1'b0;
    tick(4);
    comp_in = 1'b1;
    tick(5);
    wr(8'h01);
    tick(2);
    wr(8'h0D);
    tick(3);
    wr(8'h05);
    tick(2);

    // R8: wait mode behaves like run
    phase = "R8";
    pwr_mode = 2'b01;
    comp_in = 1'b0;
    tick(5);
    wr(8'h0D);
    comp_in = 1'b1;
    tick(5);
    wr(8'h05);
    tick(2);

    // R9: stop without stop enable is silent, with it active
    phase = "R9";
    pwr_mode = 2'b10;
    comp_in = 1'b0;
    tick(5);
    wr(8'h09);
    comp_in = 1'b1;
    tick(5);
    wr(8'h01);
    comp_in = 1'b0;
    tick(5);
    wr(8'h19);
    comp_in = 1'b1;
    tick(6);
    wr(8'h15);
    tick(2);
    comp_in = 1'b0;
    tick(5);
    pwr_mode = 2'b11;
    comp_in = 1'b1;
    tick(5);
    pwr_mode = 2'b00;
    wr(8'h05);
    tick(2);

    // R10: acknowledge swept across the cycle of the level change
    phase = "R10";
    for (int off = 0; off < 5; off++) begin
      comp_in = ~comp_in;
      tick(off);
      wr(8'h05);
      tick(4);
      wr(8'h05);
      tick(1);
    end

    // R11: reset in the middle of activity
    phase = "R11";
    wr(8'h19);
    comp_in = ~comp_in;
    tick(4);
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule